// File: doc/BRIEF.md
# Word-Portion Operand Formatter

This block sits between a memory data path and a set of 24-bit arithmetic registers. A 3-bit modifier picks which part of a word an instruction works on: the whole word, one of three 8-bit byte lanes, or the low 15-bit field. On a load, the selected portion is moved to the low end of a 24-bit operand. The upper bits are then filled with copies of the portion's top bit or with zeros. On a store, the selected low bits of a register are written into the matching place in the old memory word. Every other bit of that word is kept.

A store is a read-modify-write. The caller supplies the old memory word together with the register value, and the block returns the merged word one cycle later for writing back. Load results also appear one cycle after the request. Each result comes with its own valid strobe. If a load and a store are requested in the same cycle, only the store is carried out. Address generation and the memory array belong to the caller.

Top module: `wpf_top`

## Requirements
- R1: While rst_n is low at a clock edge, both valid strobes and both data outputs are zero on the following cycle, whatever the request inputs are.
- R2: A load with modifier 0 returns the memory word unchanged on ld_data.
- R3: A load with modifier 1, 2 or 3 places bits 7:0, 15:8 or 23:16 of the memory word in ld_data[7:0], and sets ld_data[23:8] to copies of bit 7 of that byte.
- R4: A load with modifier 5, 6 or 7 places bits 7:0, 15:8 or 23:16 of the memory word in ld_data[7:0], and sets ld_data[23:8] to zero.
- R5: A load with modifier 4 returns memory bits 14:0 in ld_data[14:0] and zeros in ld_data[23:15].
- R6: A store with modifier 0 returns the register value unchanged on st_data.
- R7: A store with modifier 1 or 5, 2 or 6, or 3 or 7 writes register bits 7:0 into byte lane 7:0, 15:8 or 23:16 of the old memory word, and keeps the other 16 bits.
- R8: A store with modifier 4 writes register bits 14:0 into bits 14:0 of the old memory word and keeps memory bits 23:15.
- R9: A request presented at one clock edge produces its result and raises its valid strobe for exactly the following cycle: ld_valid for a load, st_valid for a store.
- R10: When ld_req and st_req are both high, the store is performed and ld_valid stays low on the following cycle.
- R11: A cycle with neither request leaves both valid strobes low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load request |
| st_req | input | 1 | Store request; takes priority over ld_req |
| mod_sel | input | 3 | Portion modifier (0 to 7) |
| mem_word | input | 24 | Memory word: load source, or old word for a store |
| reg_word | input | 24 | Register value to be stored |
| ld_data | output | 24 | Formatted load operand |
| ld_valid | output | 1 | ld_data is valid this cycle |
| st_data | output | 24 | Merged word for write-back |
| st_valid | output | 1 | st_data is valid this cycle |

## Verification
The bench builds the block with its default parameters: a 24-bit word, 8-bit lanes and a 15-bit field. These are the values the modifier encoding assumes. With them, all eight modifiers can be tested for both loads and stores. Directed tests use bytes with the top bit set and clear, so that sign fill and zero fill can be told apart. The bench also tests back-to-back requests, simultaneous load and store, idle cycles and reset held while requests are high. A pseudo-random sweep then mixes modifiers, request types and data patterns.

// File: rtl/wpf_pkg.sv
// Package: shared encodings for the word-portion formatter.
// Assumes a 3-bit modifier; bit 2 clear selects sign fill for lane modes.
package wpf_pkg;

    localparam int MOD_W = 3;

    typedef enum logic [MOD_W-1:0] {
        MOD_FULL  = 3'd0,
        MOD_LO_S  = 3'd1,
        MOD_MID_S = 3'd2,
        MOD_HI_S  = 3'd3,
        MOD_FIELD = 3'd4,
        MOD_LO_Z  = 3'd5,
        MOD_MID_Z = 3'd6,
        MOD_HI_Z  = 3'd7
    } portion_e;

    // True when the modifier addresses a single byte lane.
    function automatic logic is_lane_mode(input portion_e m);
        return (m[1:0] != 2'd0);
    endfunction

    // Lane number addressed by a lane mode (low lane is 0).
    function automatic logic [1:0] lane_of(input portion_e m);
        return m[1:0] - 2'd1;
    endfunction

    // True when a lane mode extends with the lane's top bit.
    function automatic logic is_signed_mode(input portion_e m);
        return ~m[2];
    endfunction

endpackage

// File: rtl/wpf_load_extract.sv
// Load extractor: moves the selected word portion to the low end of the
// operand and extends it with sign or zero fill.
// Assumes WORD_W is a multiple of LANE_W and FIELD_W < WORD_W.
module wpf_load_extract
    import wpf_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int LANE_W  = 8,
    parameter int FIELD_W = 15
) (
    input  portion_e          mode,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] operand
);
    localparam int LANES  = WORD_W / LANE_W;
    localparam int FILL_W = WORD_W - LANE_W;

    logic [LANE_W-1:0] lane_bits [LANES];
    logic [LANE_W-1:0] picked;
    logic              fill_bit;

    // Slice the word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g] = word[g*LANE_W +: LANE_W];
    end

    // Choose the lane addressed by the modifier.
    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (is_lane_mode(mode) && (int'(lane_of(mode)) == i)) begin
                picked = lane_bits[i];
            end
        end
    end

    // Fill bit: the lane's top bit in signed modes, zero otherwise.
    assign fill_bit = is_signed_mode(mode) & picked[LANE_W-1];

    // Build the operand for the selected mode.
    always_comb begin
        operand = '0;
        if (mode == MOD_FULL) begin
            operand = word;
        end else if (mode == MOD_FIELD) begin
            operand[FIELD_W-1:0] = word[FIELD_W-1:0];
        end else begin
            operand = {{FILL_W{fill_bit}}, picked};
        end
    end

endmodule

// File: rtl/wpf_store_merge.sv
// Store merger: writes the low bits of a register into the selected place
// of the old memory word and keeps every other bit.
// Assumes WORD_W is a multiple of LANE_W and FIELD_W < WORD_W.
module wpf_store_merge
    import wpf_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int LANE_W  = 8,
    parameter int FIELD_W = 15
) (
    input  portion_e          mode,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] reg_word,
    output logic [WORD_W-1:0] merged
);
    localparam int LANES = WORD_W / LANE_W;

    logic [WORD_W-1:0] lane_merged;

    // Per lane: take the register byte when this lane is addressed.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = is_lane_mode(mode) && (int'(lane_of(mode)) == g);
        assign lane_merged[g*LANE_W +: LANE_W] =
            hit ? reg_word[LANE_W-1:0] : old_word[g*LANE_W +: LANE_W];
    end

    // Choose the merged word for the selected mode.
    always_comb begin
        if (mode == MOD_FULL) begin
            merged = reg_word;
        end else if (mode == MOD_FIELD) begin
            merged = {old_word[WORD_W-1:FIELD_W], reg_word[FIELD_W-1:0]};
        end else begin
            merged = lane_merged;
        end
    end

endmodule

// File: rtl/wpf_out_stage.sv
// Output stage: registers the load and store results with their strobes.
// A store wins over a load in the same cycle. Reset is synchronous, active-low.
module wpf_out_stage #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic              st_req,
    input  logic [WORD_W-1:0] ld_next,
    input  logic [WORD_W-1:0] st_next,
    output logic [WORD_W-1:0] ld_data,
    output logic              ld_valid,
    output logic [WORD_W-1:0] st_data,
    output logic              st_valid
);
    logic take_ld;

    assign take_ld = ld_req & ~st_req;

    // Capture the results and raise the strobes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data  <= '0;
            st_data  <= '0;
            ld_valid <= 1'b0;
            st_valid <= 1'b0;
        end else begin
            ld_valid <= take_ld;
            st_valid <= st_req;
            if (take_ld) ld_data <= ld_next;
            if (st_req)  st_data <= st_next;
        end
    end

    // R1: the first cycle after reset shows no valid strobes.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!ld_valid && !st_valid));

    // R9: a lone load produces exactly one load strobe and no store strobe.
    p_load_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req) |=> (ld_valid && !st_valid));

    // R10: a store request suppresses the load strobe.
    p_store_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> (st_valid && !ld_valid));

    // R11: an idle cycle leaves both strobes low.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && !st_req) |=> (!ld_valid && !st_valid));

endmodule

// File: rtl/wpf_top.sv
// Word-portion formatter top: formats load operands and merges store words
// according to a 3-bit modifier, with one registered stage on both paths.
// Assumes the caller supplies the old memory word together with a store.
module wpf_top
    import wpf_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int LANE_W  = 8,
    parameter int FIELD_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic              st_req,
    input  logic [MOD_W-1:0]  mod_sel,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] reg_word,
    output logic [WORD_W-1:0] ld_data,
    output logic              ld_valid,
    output logic [WORD_W-1:0] st_data,
    output logic              st_valid
);
    localparam int FILL_W = WORD_W - LANE_W;
    localparam int HIGH_W = WORD_W - FIELD_W;

    portion_e          mode;
    logic [WORD_W-1:0] ld_next;
    logic [WORD_W-1:0] st_next;

    assign mode = portion_e'(mod_sel);

    wpf_load_extract #(
        .WORD_W (WORD_W),
        .LANE_W (LANE_W),
        .FIELD_W(FIELD_W)
    ) extract_i (
        .mode   (mode),
        .word   (mem_word),
        .operand(ld_next)
    );

    wpf_store_merge #(
        .WORD_W (WORD_W),
        .LANE_W (LANE_W),
        .FIELD_W(FIELD_W)
    ) merge_i (
        .mode    (mode),
        .old_word(mem_word),
        .reg_word(reg_word),
        .merged  (st_next)
    );

    wpf_out_stage #(
        .WORD_W(WORD_W)
    ) stage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_req  (ld_req),
        .st_req  (st_req),
        .ld_next (ld_next),
        .st_next (st_next),
        .ld_data (ld_data),
        .ld_valid(ld_valid),
        .st_data (st_data),
        .st_valid(st_valid)
    );

    // R2: a full-word load returns the memory word unchanged.
    p_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && mod_sel == 3'd0) |=> (ld_data == $past(mem_word)));

    // R3: a signed lane load fills the upper bits with copies of bit 7.
    p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && !mod_sel[2] && mod_sel[1:0] != 2'd0) |=>
        (ld_data[WORD_W-1:LANE_W-1] == '0 || ld_data[WORD_W-1:LANE_W-1] == '1));

    // R4: an unsigned lane load fills the upper bits with zeros.
    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && mod_sel[2] && mod_sel[1:0] != 2'd0) |=>
        (ld_data[WORD_W-1:LANE_W] == {FILL_W{1'b0}}));

    // R5: a field load keeps the low field and clears the bits above it.
    p_field_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && mod_sel == 3'd4) |=>
        (ld_data[WORD_W-1:FIELD_W] == {HIGH_W{1'b0}} &&
         ld_data[FIELD_W-1:0] == $past(mem_word[FIELD_W-1:0])));

    // R6: a full-word store returns the register value.
    p_full_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && mod_sel == 3'd0) |=> (st_data == $past(reg_word)));

    // R7: a low-lane store keeps the upper 16 bits of the old word.
    p_lane_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && mod_sel[1:0] == 2'd1) |=>
        (st_data[WORD_W-1:LANE_W] == $past(mem_word[WORD_W-1:LANE_W])));

    // R8: a field store keeps the memory bits above the field.
    p_field_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && mod_sel == 3'd4) |=>
        (st_data[WORD_W-1:FIELD_W] == $past(mem_word[WORD_W-1:FIELD_W])));

endmodule

// File: tb/wpf_top_tb_top.sv
`timescale 1ns/1ps
module wpf_top_tb_top;

    typedef struct {
        logic        ldv;
        logic        stv;
        logic [23:0] ldd;
        logic [23:0] std;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req = 1'b0;
    logic        st_req = 1'b0;
    logic [2:0]  mod_sel = 3'd0;
    logic [23:0] mem_word = '0;
    logic [23:0] reg_word = '0;
    logic [23:0] ld_data;
    logic        ld_valid;
    logic [23:0] st_data;
    logic        st_valid;

    int   n_run = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    wpf_top dut_i (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .st_req(st_req),
        .mod_sel(mod_sel), .mem_word(mem_word), .reg_word(reg_word),
        .ld_data(ld_data), .ld_valid(ld_valid),
        .st_data(st_data), .st_valid(st_valid)
    );

    // Expected load operand, written from the requirement text.
    function automatic logic [23:0] exp_load(input logic [2:0] m, input logic [23:0] w);
        case (m)
            3'd0:    return w;
            3'd1:    return {{16{w[7]}},  w[7:0]};
            3'd2:    return {{16{w[15]}}, w[15:8]};
            3'd3:    return {{16{w[23]}}, w[23:16]};
            3'd4:    return {9'd0, w[14:0]};
            3'd5:    return {16'd0, w[7:0]};
            3'd6:    return {16'd0, w[15:8]};
            default: return {16'd0, w[23:16]};
        endcase
    endfunction

    // Expected merged store word, written from the requirement text.
    function automatic logic [23:0] exp_store(input logic [2:0] m,
                                              input logic [23:0] o,
                                              input logic [23:0] r);
        case (m)
            3'd0:       return r;
            3'd1, 3'd5: return {o[23:8], r[7:0]};
            3'd2, 3'd6: return {o[23:16], r[7:0], o[7:0]};
            3'd3, 3'd7: return {r[7:0], o[15:0]};
            default:    return {o[23:15], r[14:0]};
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and push its expected outcome.
    task automatic drive(input logic ld, input logic st, input logic [2:0] m,
                         input logic [23:0] mw, input logic [23:0] rw,
                         input string tag);
        exp_t e;
        @(negedge clk);
        ld_req = ld; st_req = st; mod_sel = m; mem_word = mw; reg_word = rw;
        e.ldv = ld & ~st;
        e.stv = st;
        e.ldd = exp_load(m, mw);
        e.std = exp_store(m, mw, rw);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge, compare the outputs with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (ld_valid !== e.ldv || st_valid !== e.stv ||
                    (e.ldv && ld_data !== e.ldd) || (e.stv && st_data !== e.std)) begin
                    n_fail++;
                    $display("FAIL %s: ldv=%0b stv=%0b ld=%h st=%h, expected ldv=%0b stv=%0b ld=%h st=%h",
                             e.tag, ld_valid, st_valid, ld_data, st_data,
                             e.ldv, e.stv, e.ldd, e.std);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset held with both requests high keeps outputs at zero.
        ld_req = 1'b1; st_req = 1'b1; mem_word = 24'hFFFFFF; reg_word = 24'hFFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (ld_valid !== 1'b0 || st_valid !== 1'b0 || ld_data !== '0 || st_data !== '0) begin
            n_fail++;
            $display("FAIL R1: ldv=%0b stv=%0b ld=%h st=%h, expected all zero",
                     ld_valid, st_valid, ld_data, st_data);
        end
        rst_n = 1'b1; ld_req = 1'b0; st_req = 1'b0;
        mon_on = 1'b1;

        drive(0, 0, 3'd0, 24'h000000, 24'h000000, "R11 idle after reset");
        drive(1, 0, 3'd0, 24'hA5C3F0, 24'h000000, "R2 full load");
        drive(1, 0, 3'd1, 24'h12347F, 24'h000000, "R3 low lane positive");
        drive(1, 0, 3'd1, 24'h123480, 24'h000000, "R3 low lane negative");
        drive(1, 0, 3'd2, 24'h00C500, 24'h000000, "R3 mid lane negative");
        drive(1, 0, 3'd3, 24'h3A0000, 24'h000000, "R3 high lane positive");
        drive(1, 0, 3'd3, 24'hF10000, 24'h000000, "R3 high lane negative");
        drive(1, 0, 3'd5, 24'hFFFF80, 24'h000000, "R4 low lane zero fill");
        drive(1, 0, 3'd6, 24'hFF9AFF, 24'h000000, "R4 mid lane zero fill");
        drive(1, 0, 3'd7, 24'hEE1111, 24'h000000, "R4 high lane zero fill");
        drive(1, 0, 3'd4, 24'hFFFFFF, 24'h000000, "R5 field load all ones");
        drive(1, 0, 3'd4, 24'h80C001, 24'h000000, "R5 field load edge");
        drive(0, 1, 3'd0, 24'h111111, 24'hABCDEF, "R6 full store");
        drive(0, 1, 3'd1, 24'h123456, 24'hFFFF9C, "R7 store low lane");
        drive(0, 1, 3'd2, 24'h123456, 24'h0000E7, "R7 store mid lane");
        drive(0, 1, 3'd3, 24'h123456, 24'h00003B, "R7 store high lane");
        drive(0, 1, 3'd5, 24'hFFFFFF, 24'h000000, "R7 store low lane unsigned mode");
        drive(0, 1, 3'd6, 24'h000000, 24'hFFFFFF, "R7 store mid lane unsigned mode");
        drive(0, 1, 3'd7, 24'hA0B0C0, 24'h5555D1, "R7 store high lane unsigned mode");
        drive(0, 1, 3'd4, 24'hFFFFFF, 24'h000000, "R8 field store keeps top");
        drive(0, 1, 3'd4, 24'h000000, 24'hFFFFFF, "R8 field store writes field");
        drive(1, 1, 3'd1, 24'h0000F0, 24'h00000F, "R10 both requests, store wins");
        drive(1, 1, 3'd4, 24'hFF8000, 24'h7FFF00, "R10 both requests field");
        drive(0, 0, 3'd3, 24'hFFFFFF, 24'hFFFFFF, "R11 idle");
        drive(1, 0, 3'd2, 24'h00FF00, 24'h000000, "R9 load after idle");
        drive(0, 1, 3'd2, 24'h00FF00, 24'h000011, "R9 store after load");
        drive(1, 0, 3'd6, 24'h007F00, 24'h000000, "R9 load after store");

        lfsr = 32'h1D2C3B4A;
        for (int i = 0; i < 300; i++) begin
            logic [23:0] a;
            logic [23:0] b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[23:0] ^ {lfsr[7:0], lfsr[31:16]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = {lfsr[15:0], lfsr[31:24]};
            drive(lfsr[27], lfsr[29], lfsr[4:2], a, b, "R9 random mix");
        end

        drive(0, 0, 3'd0, 24'h000000, 24'h000000, "R11 final idle");
        repeat (3) @(posedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule